// File: doc/BRIEF.md
# Accumulator Microcontroller Core

This block is a compact 8-bit processor core for simple embedded control. It sees a flat 16-bit byte address space. Peripherals are mapped into that space, so the same load and store instructions reach both memory and I/O. The programmer-visible state is an 8-bit accumulator, an 8-bit helper register R, a one-bit zero flag and a 16-bit program counter.

The core fetches one byte at a time through a synchronous memory port. Each read takes one cycle, so the core holds an address for two cycles and captures the data on the second. Instructions are a single opcode byte. Load, store and branch instructions carry a direct 16-bit address in the two bytes that follow the opcode. An instruction without an operand takes 3 cycles, a store or a branch takes 8 cycles, and a load takes 9.

Control and datapath are separate modules. The control sequencer drives a small bundle of strobes, and the datapath holds the registers and a combinational ALU.

Top module: `acc_core`

## Requirements
- R1: A synchronous reset clears PC, accumulator, R and the zero flag to 0. While reset is held the core presents address 0 and never writes. The first opcode is fetched from address 0.
- R2: The opcode is decoded from bits 3:0 of the instruction byte, and bits 7:4 are ignored. The encodings are: 0x0 no-op, 0x1 load, 0x2 store, 0x3 copy AC to R, 0x4 copy R to AC, 0x5 jump, 0x6 jump if zero, 0x7 jump if not zero, 0x8 add, 0x9 subtract, 0xA increment, 0xB clear, 0xC and, 0xD or, 0xE xor, 0xF invert. Load, store and the jumps are followed by a 16-bit address, low byte first.
- R3: A load copies the byte at the 16-bit operand address into AC. A store drives that full address together with AC on the write data and asserts write enable for exactly one cycle. Each store causes exactly one write.
- R4: Add computes AC+R and subtract computes AC−R. Both wrap modulo 256.
- R5: Increment adds 1 to AC with wrap. And, or and xor combine AC with R bitwise. Invert complements AC.
- R6: Add, subtract, increment, and, or, xor and invert set the zero flag to 1 when their 8-bit result is zero and to 0 otherwise.
- R7: Clear loads AC with 0 and sets the zero flag.
- R8: Copy AC to R and copy R to AC move the value unchanged. These copies, load and store leave the zero flag untouched.
- R9: Jump always loads PC with the operand. Jump-if-zero branches only when the flag is 1, and jump-if-not-zero branches only when it is 0. A branch that is not taken continues at the byte after the two address bytes.
- R10: Each read address is held for two consecutive cycles, and the returned byte is captured at the end of the second.
- R11: The no-op changes none of AC, R or the zero flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 16 | Byte address for fetch, load and store |
| memWdata | output | 8 | Store data (accumulator) |
| memWe | output | 1 | Write enable, one cycle per store |
| memRdata | input | 8 | Read data, valid one cycle after the address |

## Verification
Several properties are checked on every cycle. The reset values are checked. The read address must stay stable whenever a byte is captured. A write pulse may last only one cycle. A jump-if-zero may not redirect when the flag is clear. The zero flag must track the result after each ALU operation, must be set after a clear, and must hold across copies and no-ops. Only the directed programs can show the arithmetic and bitwise results, the low-byte-first operand order, the full 16-bit store address, and the fall-through point of an untaken branch. The same holds for the exact write count of a complete summing loop, because all of these depend on program data observed at the memory port.

// File: rtl/acc_core_pkg.sv
`timescale 1ns/1ps
package acc_core_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP  = 4'h0,
    OP_LDAC = 4'h1,
    OP_STAC = 4'h2,
    OP_MVAC = 4'h3,
    OP_MOVR = 4'h4,
    OP_JUMP = 4'h5,
    OP_JMPZ = 4'h6,
    OP_JPNZ = 4'h7,
    OP_ADD  = 4'h8,
    OP_SUB  = 4'h9,
    OP_INAC = 4'hA,
    OP_CLAC = 4'hB,
    OP_AND  = 4'hC,
    OP_OR   = 4'hD,
    OP_XOR  = 4'hE,
    OP_NOT  = 4'hF
  } opcode_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic addrSel;   // 1: operand address, 0: program counter
    logic memWe;
    logic incPc;
    logic ldPc;
    logic ldIr;
    logic ldLo;
    logic ldHi;
    logic ldAcMem;
    logic aluEn;
  } ctrlStrobe_t;

endpackage

// File: rtl/acc_core_alu.sv
`timescale 1ns/1ps
module acc_core_alu
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  opcode_e             opcode,
  input  logic [DATA_W-1:0]   accIn,
  input  logic [DATA_W-1:0]   rIn,
  output logic [DATA_W-1:0]   result,
  output logic                wrAcc,
  output logic                updZ
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    result = accIn;
    wrAcc  = 1'b1;
    unique case (opcode)
      OP_ADD:  result = accIn + rIn;
      OP_SUB:  result = accIn - rIn;
      OP_INAC: result = accIn + ONE;
      OP_CLAC: result = '0;
      OP_AND:  result = accIn & rIn;
      OP_OR:   result = accIn | rIn;
      OP_XOR:  result = accIn ^ rIn;
      OP_NOT:  result = ~accIn;
      OP_MOVR: result = rIn;
      default: wrAcc  = 1'b0;
    endcase
  end

  // every opcode with bit 3 set is a flag-producing ALU operation
  assign updZ = opcode[OPC_W-1];

endmodule

// File: rtl/acc_core_ctrl.sv
`timescale 1ns/1ps
module acc_core_ctrl
  import acc_core_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  opcode_e     opcode,
  input  logic        zFlag,
  output ctrlStrobe_t strobe
);

  typedef enum logic [3:0] {
    S_FETCH, S_FETCH_WAIT, S_DECODE,
    S_LO, S_LO_WAIT, S_HI, S_HI_WAIT,
    S_EXEC, S_LD_WAIT
  } state_e;

  state_e state, nextState;
  logic   needsAddr;

  assign needsAddr = opcode inside {OP_LDAC, OP_STAC, OP_JUMP, OP_JMPZ, OP_JPNZ};

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      S_FETCH:      nextState = S_FETCH_WAIT;
      S_FETCH_WAIT: begin
        strobe.ldIr  = 1'b1;
        strobe.incPc = 1'b1;
        nextState    = S_DECODE;
      end
      S_DECODE: begin
        if (needsAddr) nextState = S_LO;
        else begin
          strobe.aluEn = 1'b1;
          nextState    = S_FETCH;
        end
      end
      S_LO:      nextState = S_LO_WAIT;
      S_LO_WAIT: begin
        strobe.ldLo  = 1'b1;
        strobe.incPc = 1'b1;
        nextState    = S_HI;
      end
      S_HI:      nextState = S_HI_WAIT;
      S_HI_WAIT: begin
        strobe.ldHi  = 1'b1;
        strobe.incPc = 1'b1;
        nextState    = S_EXEC;
      end
      S_EXEC: begin
        nextState = S_FETCH;
        unique case (opcode)
          OP_LDAC: begin
            strobe.addrSel = 1'b1;
            nextState      = S_LD_WAIT;
          end
          OP_STAC: begin
            strobe.addrSel = 1'b1;
            strobe.memWe   = 1'b1;
          end
          OP_JUMP: strobe.ldPc = 1'b1;
          OP_JMPZ: strobe.ldPc = zFlag;
          OP_JPNZ: strobe.ldPc = ~zFlag;
          default: ;
        endcase
      end
      S_LD_WAIT: begin
        strobe.addrSel = 1'b1;
        strobe.ldAcMem = 1'b1;
        nextState      = S_FETCH;
      end
      default: nextState = S_FETCH;
    endcase
  end

  // R3
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.memWe |=> !strobe.memWe);

  // R9
  jmpz_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && opcode == OP_JMPZ && !zFlag) |-> !strobe.ldPc);

  // R9
  jpnz_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && opcode == OP_JPNZ && zFlag) |-> !strobe.ldPc);

endmodule

// File: rtl/acc_core_dp.sv
`timescale 1ns/1ps
module acc_core_dp
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output opcode_e           opcode,
  output logic              zFlag
);

  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] acc, rReg;
  logic [DATA_W-1:0] opLo;
  logic [HI_W-1:0]   opHi;
  logic [DATA_W-1:0] aluResult;
  logic              aluWrAcc, aluUpdZ;
  logic [ADDR_W-1:0] target;

  assign target   = {opHi, opLo};
  assign memAddr  = strobe.addrSel ? target : pc;
  assign memWdata = acc;

  acc_core_alu #(.DATA_W(DATA_W)) alu_i (
    .opcode (opcode),
    .accIn  (acc),
    .rIn    (rReg),
    .result (aluResult),
    .wrAcc  (aluWrAcc),
    .updZ   (aluUpdZ)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      acc    <= '0;
      rReg   <= '0;
      zFlag  <= 1'b0;
      opcode <= OP_NOP;
      opLo   <= '0;
      opHi   <= '0;
    end else begin
      if (strobe.ldIr)    opcode <= opcode_e'(memRdata[OPC_W-1:0]);
      if (strobe.incPc)   pc     <= pc + PC_STEP;
      if (strobe.ldPc)    pc     <= target;
      if (strobe.ldLo)    opLo   <= memRdata;
      if (strobe.ldHi)    opHi   <= memRdata[HI_W-1:0];
      if (strobe.ldAcMem) acc    <= memRdata;
      if (strobe.aluEn) begin
        if (aluWrAcc)           acc   <= aluResult;
        if (aluUpdZ)            zFlag <= (aluResult == '0);
        if (opcode == OP_MVAC)  rReg  <= acc;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pc == '0 && acc == '0 && rReg == '0 && !zFlag));

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.ldIr || strobe.ldLo || strobe.ldHi || strobe.ldAcMem) |-> $stable(memAddr));

  // R6
  zero_track_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.aluEn && opcode inside {OP_ADD, OP_SUB, OP_INAC, OP_AND, OP_OR, OP_XOR, OP_NOT})
      |=> (zFlag == (acc == '0)));

  // R7
  clac_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.aluEn && opcode == OP_CLAC) |=> (acc == '0 && zFlag));

  // R8
  move_keeps_z_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.aluEn && opcode inside {OP_MVAC, OP_MOVR}) |=> $stable(zFlag));

  // R11
  nop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.aluEn && opcode == OP_NOP) |=> ($stable(acc) && $stable(rReg) && $stable(zFlag)));

endmodule

// File: rtl/acc_core.sv
`timescale 1ns/1ps
module acc_core
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  input  logic [DATA_W-1:0] memRdata
);

  ctrlStrobe_t strobe;
  opcode_e     opcode;
  logic        zFlag;

  acc_core_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .zFlag  (zFlag),
    .strobe (strobe)
  );

  acc_core_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .opcode   (opcode),
    .zFlag    (zFlag)
  );

  assign memWe = strobe.memWe;

endmodule

// File: tb/acc_core_tb_top.sv
`timescale 1ns/1ps
module acc_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_N = 512;
  localparam int RUN_CYC = 400;

  localparam logic [7:0] I_NOP = 8'h00, I_LD = 8'h01, I_ST = 8'h02, I_A2R = 8'h03,
                         I_R2A = 8'h04, I_JMP = 8'h05, I_JZ = 8'h06, I_JNZ = 8'h07,
                         I_ADD = 8'h08, I_SUB = 8'h09, I_INC = 8'h0A, I_CLR = 8'h0B,
                         I_AND = 8'h0C, I_OR = 8'h0D, I_XOR = 8'h0E, I_INV = 8'h0F;
  localparam logic [15:0] MK_TAKEN = 16'h01F0, MK_FALL = 16'h01F1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] memAddr;
  logic [7:0]  memWdata;
  logic        memWe;
  logic [7:0]  memRdata;

  logic [7:0]  mem [MEM_N];
  int          wrCount;
  logic [15:0] lastWrAddr;
  int          pcW;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core dut_i (
    .clk      (clk),
    .rst      (rst),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe),
    .memRdata (memRdata)
  );

  always @(posedge clk) begin
    memRdata <= mem[memAddr[8:0]];
    if (memWe) begin
      mem[memAddr[8:0]] <= memWdata;
      wrCount    = wrCount + 1;
      lastWrAddr = memAddr;
    end
  end

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < MEM_N; i++) mem[i] = 8'h00;
    mem[MK_TAKEN[8:0]] = 8'h11;
    mem[MK_FALL[8:0]]  = 8'h22;
    pcW = 0;
  endtask

  task automatic emit(input logic [7:0] b);
    mem[pcW[8:0]] = b;
    pcW++;
  endtask

  task automatic emitA(input logic [7:0] op, input logic [15:0] a);
    emit(op);
    emit(a[7:0]);
    emit(a[15:8]);
  endtask

  task automatic halt();
    emitA(I_JMP, 16'(pcW));
  endtask

  // branch probe: writes 0x11 to out when taken, 0x22 when it falls through
  task automatic brTail(input logic [7:0] op, input logic [15:0] out);
    int tgt;
    int fin;
    tgt = pcW + 12;
    fin = tgt + 6;
    emitA(op, 16'(tgt));
    emitA(I_LD, MK_FALL);
    emitA(I_ST, out);
    emitA(I_JMP, 16'(fin));
    emitA(I_LD, MK_TAKEN);
    emitA(I_ST, out);
    emitA(I_JMP, 16'(fin));
  endtask

  task automatic runProg(input int cycles);
    rst = 1'b1;
    wrCount = 0;
    lastWrAddr = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    clearMem();
    halt();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "address during reset", memAddr, 16'h0000);
    chk("R1", "write enable during reset", 16'(memWe), 16'h0000);
    rst = 1'b0;
    chk("R1", "first fetch address", memAddr, 16'h0000);
    @(negedge clk);
    chk("R10", "fetch address held second cycle", memAddr, 16'h0000);
    @(negedge clk);
    chk("R10", "next address after capture", memAddr, 16'h0001);
  endtask

  task automatic testLoadStore();
    clearMem();
    mem[9'h100] = 8'h5A;
    emitA(I_LD, 16'h0100);
    emitA(I_ST, 16'hA180);
    halt();
    runProg(RUN_CYC);
    chk("R3", "stored byte", 16'(mem[9'h180]), 16'h005A);
    chk("R2", "store address low byte first", lastWrAddr, 16'hA180);
    chk("R3", "single write", 16'(wrCount), 16'd1);
  endtask

  task automatic testArith();
    clearMem();
    mem[9'h100] = 8'h20; mem[9'h101] = 8'hF0;
    mem[9'h102] = 8'h05; mem[9'h103] = 8'h03;
    emitA(I_LD, 16'h0100); emit(I_A2R); emitA(I_LD, 16'h0101); emit(I_ADD); emitA(I_ST, 16'h0180);
    emitA(I_LD, 16'h0102); emit(I_A2R); emitA(I_LD, 16'h0103); emit(I_SUB); emitA(I_ST, 16'h0181);
    emitA(I_LD, 16'h0103); emit(I_A2R); emitA(I_LD, 16'h0102); emit(I_SUB); emitA(I_ST, 16'h0182);
    brTail(I_JNZ, 16'h0183);
    runProg(RUN_CYC);
    chk("R4", "add wraps", 16'(mem[9'h180]), 16'h0010);
    chk("R4", "sub is AC minus R, wraps", 16'(mem[9'h181]), 16'h00FE);
    chk("R4", "sub positive", 16'(mem[9'h182]), 16'h0002);
    chk("R6", "nonzero result clears flag", 16'(mem[9'h183]), 16'h0011);
  endtask

  task automatic testLogic();
    clearMem();
    mem[9'h100] = 8'hCC; mem[9'h101] = 8'hAA;
    emitA(I_LD, 16'h0100); emit(I_A2R);
    emitA(I_LD, 16'h0101); emit(I_AND); emitA(I_ST, 16'h0180);
    emitA(I_LD, 16'h0101); emit(I_OR);  emitA(I_ST, 16'h0181);
    emitA(I_LD, 16'h0101); emit(I_XOR); emitA(I_ST, 16'h0182);
    emitA(I_LD, 16'h0101); emit(I_INV); emitA(I_ST, 16'h0183);
    emit(I_R2A); emitA(I_ST, 16'h0184);
    emitA(I_LD, 16'h0100); emit(I_XOR); brTail(I_JZ, 16'h0185);
    runProg(RUN_CYC);
    chk("R5", "and", 16'(mem[9'h180]), 16'h0088);
    chk("R5", "or", 16'(mem[9'h181]), 16'h00EE);
    chk("R5", "xor", 16'(mem[9'h182]), 16'h0066);
    chk("R5", "invert", 16'(mem[9'h183]), 16'h0055);
    chk("R8", "copy R to AC", 16'(mem[9'h184]), 16'h00CC);
    chk("R6", "xor to zero sets flag", 16'(mem[9'h185]), 16'h0011);
  endtask

  task automatic testZeroAdd();
    clearMem();
    mem[9'h100] = 8'h01; mem[9'h101] = 8'hFF;
    emitA(I_LD, 16'h0100); emit(I_A2R); emitA(I_LD, 16'h0101); emit(I_ADD);
    emitA(I_ST, 16'h0180);
    brTail(I_JZ, 16'h0181);
    runProg(RUN_CYC);
    chk("R4", "add wraps to zero", 16'(mem[9'h180]), 16'h0000);
    chk("R6", "zero sum sets flag", 16'(mem[9'h181]), 16'h0011);
  endtask

  task automatic testInac();
    clearMem();
    mem[9'h100] = 8'h41; mem[9'h101] = 8'hFF;
    emitA(I_LD, 16'h0100); emit(I_INC); emitA(I_ST, 16'h0182);
    emitA(I_LD, 16'h0101); emit(I_INC); emitA(I_ST, 16'h0180);
    brTail(I_JZ, 16'h0181);
    runProg(RUN_CYC);
    chk("R5", "increment", 16'(mem[9'h182]), 16'h0042);
    chk("R5", "increment wraps", 16'(mem[9'h180]), 16'h0000);
    chk("R6", "increment to zero sets flag", 16'(mem[9'h181]), 16'h0011);
  endtask

  task automatic testClac();
    clearMem();
    mem[9'h100] = 8'h77;
    emitA(I_LD, 16'h0100); emit(I_CLR); emitA(I_ST, 16'h0180);
    brTail(I_JNZ, 16'h0181);
    runProg(RUN_CYC);
    chk("R7", "clear zeroes AC", 16'(mem[9'h180]), 16'h0000);
    chk("R9", "untaken branch falls through", 16'(mem[9'h181]), 16'h0022);
  endtask

  task automatic testMoveZ();
    clearMem();
    mem[9'h100] = 8'h3C; mem[9'h101] = 8'h99;
    emit(I_CLR);
    emitA(I_LD, 16'h0100); emit(I_A2R); emitA(I_LD, 16'h0101); emit(I_R2A);
    emitA(I_ST, 16'h0180);
    brTail(I_JZ, 16'h0181);
    runProg(RUN_CYC);
    chk("R8", "R round trip", 16'(mem[9'h180]), 16'h003C);
    chk("R8", "copies and load keep flag", 16'(mem[9'h181]), 16'h0011);
  endtask

  task automatic testNop();
    clearMem();
    mem[9'h100] = 8'hA5;
    emit(I_CLR); emitA(I_LD, 16'h0100); emit(I_NOP); emit(I_NOP); emit(8'hF0);
    emitA(I_ST, 16'h0180);
    brTail(I_JZ, 16'h0181);
    runProg(RUN_CYC);
    chk("R11", "no-op keeps AC", 16'(mem[9'h180]), 16'h00A5);
    chk("R11", "no-op keeps flag", 16'(mem[9'h181]), 16'h0011);
  endtask

  task automatic testJump();
    clearMem();
    brTail(I_JMP, 16'h0180);
    runProg(RUN_CYC);
    chk("R9", "unconditional jump", 16'(mem[9'h180]), 16'h0011);
    clearMem();
    brTail(I_JZ, 16'h0180);
    runProg(RUN_CYC);
    chk("R9", "jump-if-zero with clear flag", 16'(mem[9'h180]), 16'h0022);
  endtask

  task automatic testSumLoop();
    clearMem();
    mem[9'h100] = 8'h05;
    emit(I_CLR); emitA(I_ST, 16'h0191); emitA(I_ST, 16'h0190);
    emitA(I_LD, 16'h0190); emit(I_INC); emitA(I_ST, 16'h0190); emit(I_A2R);
    emitA(I_LD, 16'h0191); emit(I_ADD); emitA(I_ST, 16'h0191);
    emitA(I_LD, 16'h0100); emit(I_SUB); emitA(I_JNZ, 16'h0007);
    halt();
    runProg(800);
    chk("R9", "loop total", 16'(mem[9'h191]), 16'd15);
    chk("R9", "loop counter", 16'(mem[9'h190]), 16'd5);
    chk("R3", "loop write count", 16'(wrCount), 16'd12);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    clearMem();
    testReset();
    testLoadStore();
    testArith();
    testLogic();
    testZeroAdd();
    testInac();
    testClac();
    testMoveZ();
    testNop();
    testJump();
    testSumLoop();
    finishRun();
  end

endmodule